// File: doc/BRIEF.md
# Double-Buffered Converter Input Register

This block is the digital front end of a 12-bit converter whose host bus is only 8 bits wide. A word reaches the converter in two parts. A low byte is steered into the input latch under an active-low low-part select. A high nibble, taken from the four least significant bus lines, is steered into the same latch under an active-low high-part select. A write strobe qualifies both selects. A separate active-low load strobe copies the assembled input latch into a second register, the converter latch, whose 12-bit code is the output.

All strobes and the data bus arrive from another timing domain and are sampled on a fast system clock. The level-sensitive behaviour is therefore modelled in sampled form. While a select and the write strobe are both low, that part of the input latch takes the bus value on every clock. While the load strobe is low, the converter latch takes the next value of the input latch on every clock. Each latch keeps its value once its strobe is released. The load strobe is independent of the write path. When the high-part select, the write strobe and the load strobe are all low together, the nibble is loaded and the whole word is transferred in one step. If the load strobe overlaps a write, it must stay low for a set number of clocks after the write ends. A sticky flag reports any earlier release.

Top module: `dac_dbuf_front`

## Requirements
- R1: After reset the output code is 0x000 and the violation flag is 0.
- R2: While the low-part select and the write strobe are both low, bus bits 7:0 are copied into bits 7:0 of the input latch on every clock. Once either strobe is high, those bits hold.
- R3: While the high-part select and the write strobe are both low, bus bits 3:0 are copied into bits 11:8 of the input latch. Bus bits 7:4 have no effect on the high nibble.
- R4: While the load strobe is high, writes to the input latch leave the output code unchanged.
- R5: While the load strobe is low, the output code follows the input latch, including writes made during that time. After the load strobe rises, the code holds.
- R6: With the high-part select, the write strobe and the load strobe all low, the new nibble reaches bits 11:8 of the output code on the same clock that it enters the input latch.
- R7: With all four strobes high, changes on the bus have no effect on the output code.
- R8: A change at the strobe and bus pins first shows on the outputs after the third rising clock edge, which allows two synchronizer stages and one register stage.
- R9: An overlap occurs when the load strobe, the write strobe and either select are low together. If the load strobe then rises while the write strobe is still low, or within HOLD_CYC clocks after the write strobe rises, the violation flag goes to 1. It stays at 1 until reset.
- R10: If, after an overlap, the load strobe rises HOLD_CYC+1 or more clocks after the write strobe, the violation flag stays at 0.
- R11: A select held low while the write strobe is high loads nothing into the input latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 8 | Host data bus |
| lo_sel_n | input | 1 | Low-byte select, active low |
| hi_sel_n | input | 1 | High-nibble select, active low |
| wr_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | Load (transfer) strobe, active low |
| code_o | output | 12 | Converter latch code |
| hold_err_o | output | 1 | Sticky load-hold violation flag |

## Verification
On every clock the assertions check four things:
- each half of the input latch changes only after its select-and-write condition was present;
- the output code changes only after a sampled low load level;
- a combined high-select, write and load step delivers the bus nibble to the code;
- the violation flag never clears by itself and only sets after a load rise.

Some behaviours only the bench scenarios show:
- the three-edge latency;
- the follow-then-hold behaviour of the load strobe;
- the exact boundary of the hold window at HOLD_CYC versus HOLD_CYC+1 clocks;
- the absence of any effect from selects without a write or from bus activity while idle.

The bench's clock-by-clock reference model checks these scenarios.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

    typedef struct packed {
        logic lo_n;
        logic hi_n;
        logic wr_n;
        logic ld_n;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);
    localparam strobe_t STROBE_IDLE = '{lo_n: 1'b1, hi_n: 1'b1, wr_n: 1'b1, ld_n: 1'b1};

endpackage

// File: rtl/dac_dbuf_sync.sv
module dac_dbuf_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/dac_dbuf_inlatch.sv
module dac_dbuf_inlatch #(
    parameter int LO_W = 8,
    parameter int HI_W = 4,
    localparam int W   = LO_W + HI_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lo_en_i,
    input  logic            hi_en_i,
    input  logic [LO_W-1:0] bus_i,
    output logic [W-1:0]    word_d_o,
    output logic [W-1:0]    word_q_o
);

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } word_t;

    word_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (lo_en_i) w_d.lo = bus_i;
        if (hi_en_i) w_d.hi = bus_i[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign word_d_o = w_d;
    assign word_q_o = w_q;

    // R2: low byte only moves after its select-and-write condition
    a_r2_lo_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.lo != $past(w_q.lo)) |-> $past(lo_en_i));

    // R3 / R11: high nibble only moves after its select-and-write condition
    a_r3_hi_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.hi != $past(w_q.hi)) |-> $past(hi_en_i));

endmodule

// File: rtl/dac_dbuf_holdmon.sv
module dac_dbuf_holdmon #(
    parameter int HOLD_CYC = 4,
    localparam int CNT_W   = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n_i,
    input  logic ld_n_i,
    input  logic sel_low_i,
    output logic err_o
);

    typedef struct packed {
        logic             wr_prev;
        logic             ld_prev;
        logic             ovl;
        logic [CNT_W-1:0] win;
        logic             err;
    } mon_t;

    mon_t m_d, m_q;
    logic wr_rise, ld_rise, all_low, win_open;

    always_comb begin
        wr_rise  = wr_n_i && !m_q.wr_prev;
        ld_rise  = ld_n_i && !m_q.ld_prev;
        all_low  = !wr_n_i && !ld_n_i && sel_low_i;
        win_open = (m_q.win != '0);

        m_d         = m_q;
        m_d.wr_prev = wr_n_i;
        m_d.ld_prev = ld_n_i;

        if (ld_rise && (m_q.ovl || win_open)) m_d.err = 1'b1;

        if (wr_rise && m_q.ovl)  m_d.win = CNT_W'(HOLD_CYC);
        else if (win_open)       m_d.win = m_q.win - 1'b1;

        if (wr_rise || ld_rise)  m_d.ovl = 1'b0;
        else if (all_low)        m_d.ovl = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{wr_prev: 1'b1, ld_prev: 1'b1, ovl: 1'b0, win: '0, err: 1'b0};
        end else begin
            m_q <= m_d;
        end
    end

    assign err_o = m_q.err;

    // R9: the flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.err |=> m_q.err);

    // R9: the flag only sets after a sampled load release
    a_r9_err_after_ld_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.err && !$past(m_q.err)) |-> $past(ld_n_i && !m_q.ld_prev));

    // R10: the window never exceeds the hold length
    a_r10_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.win <= CNT_W'(HOLD_CYC));

endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front #(
    parameter int BUS_W       = 8,
    parameter int HI_W        = 4,
    parameter int HOLD_CYC    = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CODE_W     = BUS_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_i,
    input  logic              lo_sel_n,
    input  logic              hi_sel_n,
    input  logic              wr_n,
    input  logic              ld_n,
    output logic [CODE_W-1:0] code_o,
    output logic              hold_err_o
);

    import dac_dbuf_pkg::*;

    strobe_t            st_raw, st_s;
    logic [BUS_W-1:0]   bus_s;
    logic [CODE_W-1:0]  word_d, word_q;
    logic               wr_low, ld_low, lo_en, hi_en;

    assign st_raw = '{lo_n: lo_sel_n, hi_n: hi_sel_n, wr_n: wr_n, ld_n: ld_n};

    dac_dbuf_sync #(.W(STROBE_W), .STAGES(SYNC_STAGES), .RST_VAL(STROBE_IDLE)) u_sync_st (
        .clk(clk), .rst_n(rst_n), .d_i(st_raw), .q_o(st_s)
    );

    dac_dbuf_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
        .clk(clk), .rst_n(rst_n), .d_i(bus_i), .q_o(bus_s)
    );

    assign wr_low = !st_s.wr_n;
    assign ld_low = !st_s.ld_n;
    assign lo_en  = wr_low && !st_s.lo_n;
    assign hi_en  = wr_low && !st_s.hi_n;

    dac_dbuf_inlatch #(.LO_W(BUS_W), .HI_W(HI_W)) u_inlatch (
        .clk(clk), .rst_n(rst_n), .lo_en_i(lo_en), .hi_en_i(hi_en),
        .bus_i(bus_s), .word_d_o(word_d), .word_q_o(word_q)
    );

    dac_dbuf_holdmon #(.HOLD_CYC(HOLD_CYC)) u_holdmon (
        .clk(clk), .rst_n(rst_n), .wr_n_i(st_s.wr_n), .ld_n_i(st_s.ld_n),
        .sel_low_i(!st_s.lo_n || !st_s.hi_n), .err_o(hold_err_o)
    );

    typedef struct packed {
        logic [CODE_W-1:0] dac;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (ld_low) o_d.dac = word_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign code_o = o_q.dac;

    // R4 / R5: the code only moves after a sampled low load level
    a_r4_code_moves_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != $past(code_o)) |-> $past(ld_low));

    // R6: combined high-select, write and load delivers the nibble at once
    a_r6_nibble_same_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_low && hi_en) |=> (code_o[CODE_W-1:BUS_W] == $past(bus_s[HI_W-1:0])));

    // R5: while load stays low the code equals the input latch
    a_r5_follow_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ld_low |=> (code_o == word_q));

endmodule

// File: tb/dac_dbuf_front_bench.sv
module dac_dbuf_front_bench;

    localparam int HOLD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus = 8'h00;
    logic        lo_n = 1'b1, hi_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
    logic [11:0] code;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dac_dbuf_front #(.HOLD_CYC(HOLD)) u_dac_dbuf_front (
        .clk(clk), .rst_n(rst_n), .bus_i(bus), .lo_sel_n(lo_n), .hi_sel_n(hi_n),
        .wr_n(wr_n), .ld_n(ld_n), .code_o(code), .hold_err_o(err)
    );

    // reference model: queue of pin samples, {bus, lo, hi, wr, ld}
    logic [11:0] hist[$];
    int lo_m, hi_m, dac_m, win_m;
    bit ov_m, err_m;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            repeat (3) hist.push_back(12'h00F);
            lo_m = 0; hi_m = 0; dac_m = 0; win_m = 0; ov_m = 0; err_m = 0;
        end else begin
            logic [11:0] e, p;
            bit ldr, wrr;
            hist.push_back({bus, lo_n, hi_n, wr_n, ld_n});
            e = hist[hist.size()-3];
            p = hist[hist.size()-4];
            if (!e[1] && !e[3]) lo_m = int'(e[11:4]);
            if (!e[1] && !e[2]) hi_m = int'(e[7:4]);
            ldr = e[0] && !p[0];
            wrr = e[1] && !p[1];
            if (ldr && (ov_m || win_m > 0)) err_m = 1;
            if (wrr && ov_m) win_m = HOLD;
            else if (win_m > 0) win_m = win_m - 1;
            if (wrr || ldr) ov_m = 0;
            else if (!e[0] && !e[1] && (!e[2] || !e[3])) ov_m = 1;
            if (!e[0]) dac_m = hi_m * 256 + lo_m;
            if (hist.size() > 8) void'(hist.pop_front());
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R8: cycle-exact comparison against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 model code", int'(code), dac_m);
            chk("R9 model flag", int'(err), int'(err_m));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_lo(logic [7:0] v);
        bus = v; lo_n = 1'b0; wr_n = 1'b0;
        tick(2);
        wr_n = 1'b1; lo_n = 1'b1;
        tick(4);
    endtask

    task automatic write_hi(logic [7:0] v);
        bus = v; hi_n = 1'b0; wr_n = 1'b0;
        tick(2);
        wr_n = 1'b1; hi_n = 1'b1;
        tick(4);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        chk("R1 reset code", int'(code), 0);
        chk("R1 reset flag", int'(err), 0);

        write_lo(8'hA5);
        chk("R4 low write without load", int'(code), 0);
        write_hi(8'hF3);
        chk("R4 high write without load", int'(code), 0);

        // R8: latency from load pin to code
        ld_n = 1'b0;
        tick(1); chk("R8 edge 1", int'(code), 0);
        tick(1); chk("R8 edge 2", int'(code), 0);
        tick(1); chk("R8 edge 3 R2 R3", int'(code), 'h3A5);
        tick(2);

        // R5: follow while low, hold after release
        bus = 8'h22; lo_n = 1'b0; wr_n = 1'b0;
        tick(2);
        wr_n = 1'b1; lo_n = 1'b1;
        tick(HOLD + 4);
        chk("R5 follow", int'(code), 'h322);
        ld_n = 1'b1;
        tick(4);
        chk("R10 long hold", int'(err), 0);
        write_lo(8'h33);
        chk("R5 hold after release", int'(code), 'h322);

        // R6: combined nibble load and transfer
        bus = 8'h07; hi_n = 1'b0; wr_n = 1'b0; ld_n = 1'b0;
        tick(2);
        wr_n = 1'b1; hi_n = 1'b1;
        tick(HOLD + 2);
        ld_n = 1'b1;
        tick(4);
        chk("R6 combined step", int'(code), 'h733);
        chk("R6 no violation", int'(err), 0);

        // R11: selects without write
        bus = 8'h5C; lo_n = 1'b0; hi_n = 1'b0;
        tick(3);
        lo_n = 1'b1; hi_n = 1'b1;
        tick(1);
        ld_n = 1'b0; tick(3); ld_n = 1'b1; tick(4);
        chk("R11 select without write", int'(code), 'h733);

        // R7: bus activity while idle
        for (int i = 0; i < 6; i++) begin
            bus = (i % 2 == 0) ? 8'hFF : 8'h00;
            tick(1);
        end
        tick(4);
        chk("R7 idle bus", int'(code), 'h733);
        chk("R7 idle flag", int'(err), 0);

        // R10: release exactly HOLD+1 clocks after write
        bus = 8'h81; lo_n = 1'b0; wr_n = 1'b0; ld_n = 1'b0;
        tick(2);
        wr_n = 1'b1; lo_n = 1'b1;
        tick(HOLD + 1);
        ld_n = 1'b1;
        tick(4);
        chk("R10 boundary flag", int'(err), 0);
        chk("R10 boundary code", int'(code), 'h781);

        // R9: release HOLD clocks after write
        bus = 8'h4E; lo_n = 1'b0; wr_n = 1'b0; ld_n = 1'b0;
        tick(2);
        wr_n = 1'b1; lo_n = 1'b1;
        tick(HOLD);
        ld_n = 1'b1;
        tick(4);
        chk("R9 early release", int'(err), 1);
        chk("R9 code", int'(code), 'h74E);

        // R9: sticky through clean traffic
        write_lo(8'h10);
        ld_n = 1'b0; tick(3); ld_n = 1'b1; tick(4);
        chk("R9 sticky", int'(err), 1);
        chk("R2 clean transfer", int'(code), 'h710);

        // R1: reset again
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        chk("R1 re-reset code", int'(code), 0);
        chk("R1 re-reset flag", int'(err), 0);

        tick(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule